// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog that escalates in two steps. An interval counter runs while the watchdog is enabled and wraps every 2^N clock cycles. The first wrap sets a pending-expiry flag, and that flag drives the interrupt output as a level. If software does not service the watchdog before the next wrap, the block issues a system-reset pulse of fixed length and sets a sticky reset-cause flag. Software can read the reset-cause flag once the system comes back up.

Software reaches the block through a simple 32-bit register bus with single-cycle read and write strobes. It sees two control/status words and a free-running timebase counter. The watchdog is enabled through either of two enable bits, which sit in separate words. It services the watchdog by writing a one to the pending flag. A build option locks the watchdog so that it stays on once it has been enabled.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, `irq_o` and `sys_rst_o` are low, and control word A (offset 0x0) and control word B (offset 0x4) both read 0.
- R2: Control word A holds the reset-cause flag at bit 3, the pending flag at bit 2 and enable A at bit 1. Control word B holds enable B at bit 0. The timebase sits at offset 0x8. Any other offset reads 0, and every undefined bit reads 0.
- R3: The timebase advances by one on every clock. Two reads whose strobes are two cycles apart return values that differ by exactly 2.
- R4: The interval counter runs while either enable bit is set. Enable B on its own is enough to run it.
- R5: The first wrap sets the pending flag, and `irq_o` rises exactly 2^N clocks after the write edge that enabled the counter. `irq_o` follows the pending flag as a level.
- R6: Writing word A with bit 2 set clears the pending flag, so `irq_o` drops. The same write restarts the interval, so the next interrupt comes a full 2^N clocks after the servicing write.
- R7: A wrap that occurs while the pending flag is set drives `sys_rst_o` high for exactly 4 cycles and sets the reset-cause flag. The reset-cause flag stays set after the pulse ends, and it survives a disable.
- R8: Writing word A with bit 3 set clears the reset-cause flag. Writing 0 to bits 3 and 2 leaves both flags as they are.
- R9: When both enable bits are clear, the counter stops and returns to zero. A later enable therefore waits a full 2^N clocks before the interrupt.
- R10: When built with the lock option, once either enable bit is set, writes of 0 to the enable bits are ignored and the counter keeps running.
- R11: Writes to bit 0 of word A and to undefined bits have no effect. Such a write does not enable the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; the data is valid on the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt level; high while the pending flag is set |
| sys_rst_o | output | 1 | System reset pulse raised on the second expiry |

## Verification
The bench measures the exact clock on which the interrupt rises. It does so after a plain enable, after a service and after a disable/re-enable sequence. A design that did not restart the interval on service or on disable would raise the interrupt early, and one that was off by a cycle would miss the sampled edge. The bench counts the reset pulse cycle by cycle, so a pulse that is too long, too short or raised on the first wrap is caught. It also shows that the reset-cause flag outlives both the pulse and a disable. Further checks show that writes of 0 to the flags, writes to bit 0 and writes to undefined bits leave the flags and the enable state alone. A locked instance is checked to keep counting after software tries to clear both enables.

// File: rtl/twdt_pkg.sv
package twdt_pkg;
  // Byte offsets of the three visible words
  localparam int unsigned OFS_CTLA = 'h0;
  localparam int unsigned OFS_CTLB = 'h4;
  localparam int unsigned OFS_TIME = 'h8;

  // Bit positions within the control words
  localparam int unsigned BIT_CAUSE = 3;
  localparam int unsigned BIT_PEND  = 2;
  localparam int unsigned BIT_ENA   = 1;
  localparam int unsigned BIT_ENB   = 0;

  typedef enum logic [1:0] {
    SEL_CTLA = 2'd0,
    SEL_CTLB = 2'd1,
    SEL_TIME = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;
endpackage

// File: rtl/twdt_timebase.sv
module twdt_timebase #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] time_o
);
  logic [W-1:0] time_q, time_d;

  always_comb begin
    time_d = time_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assign time_o = time_q;

  // R3: advances by exactly one every clock
  assert_time_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> time_q == $past(time_q) + W'(1));
endmodule

// File: rtl/twdt_regs.sv
module twdt_regs
  import twdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TB_W   = 32,
  parameter bit          LOCK   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  input  logic              pend_i,
  input  logic              cause_i,
  input  logic [TB_W-1:0]   time_i,
  output logic [31:0]       rdata_o,
  output logic              active_o,
  output logic              service_o,
  output logic              clr_cause_o
);
  word_sel_e   sel;
  logic        ena_q, ena_d, enb_q, enb_d;
  logic        locked;
  logic [31:0] rdata_q, rdata_d;
  logic        unused_wbits;

  assign unused_wbits = ^{wdata_i[31:4], wdata_i[BIT_ENB]};

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_CTLA)) sel = SEL_CTLA;
    else if (addr_i == ADDR_W'(OFS_CTLB)) sel = SEL_CTLB;
    else if (addr_i == ADDR_W'(OFS_TIME)) sel = SEL_TIME;
    else                                  sel = SEL_NONE;
  end

  // Lock: once running, enables can only be set
  assign locked = LOCK && (ena_q || enb_q);

  always_comb begin
    ena_d = ena_q;
    enb_d = enb_q;
    if (wr_i && sel == SEL_CTLA) ena_d = wdata_i[BIT_ENA] | (locked & ena_q);
    if (wr_i && sel == SEL_CTLB) enb_d = wdata_i[BIT_ENB] | (locked & enb_q);
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) begin
      unique case (sel)
        SEL_CTLA: rdata_d = {28'd0, cause_i, pend_i, ena_q, 1'b0};
        SEL_CTLB: rdata_d = {31'd0, enb_q};
        SEL_TIME: rdata_d = 32'(time_i);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q   <= 1'b0;
      enb_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ena_q   <= ena_d;
      enb_q   <= enb_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o     = rdata_q;
  assign active_o    = ena_q | enb_q;
  assign service_o   = wr_i && sel == SEL_CTLA && wdata_i[BIT_PEND];
  assign clr_cause_o = wr_i && sel == SEL_CTLA && wdata_i[BIT_CAUSE];

  // R10: a locked watchdog never turns off
  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCK && $past(active_o)) |-> active_o);

  // R2: undecoded offsets read as zero
  assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel == SEL_NONE) |=> rdata_o == 32'd0);
endmodule

// File: rtl/twdt_expiry.sv
module twdt_expiry #(
  parameter int unsigned N         = 16,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic service_i,
  input  logic clr_cause_i,
  output logic pend_o,
  output logic cause_o,
  output logic sys_rst_o
);
  localparam int unsigned PW = $clog2(RST_PULSE + 1);

  logic [N-1:0]  cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          cause_q, cause_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          wrap, second;

  assign wrap   = active_i && !service_i && (cnt_q == '1);
  assign second = wrap && pend_q;

  always_comb begin
    cnt_d = (!active_i || service_i) ? '0 : cnt_q + N'(1);

    pend_d = pend_q;
    if (service_i)  pend_d = 1'b0;
    else if (wrap)  pend_d = 1'b1;

    cause_d = cause_q;
    if (second)           cause_d = 1'b1;
    else if (clr_cause_i) cause_d = 1'b0;

    pulse_d = pulse_q;
    if (second)                pulse_d = PW'(RST_PULSE);
    else if (pulse_q != '0)    pulse_d = pulse_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      cause_q <= 1'b0;
      pulse_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      cause_q <= cause_d;
      pulse_q <= pulse_d;
    end
  end

  assign pend_o    = pend_q;
  assign cause_o   = cause_q;
  assign sys_rst_o = (pulse_q != '0);

  // R7: reset only escalates from an already pending expiry
  assert_rst_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(pend_q));

  // R7: the cause flag is set whenever reset is driven
  assert_rst_marks_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> cause_q);

  // R5: the pending flag rises only out of an enabled, unserviced interval
  assert_pend_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(active_i) && !$past(service_i)));

  // R9: a disabled watchdog holds its interval at zero
  assert_idle_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned INTERVAL_LOG2 = 16,
  parameter int unsigned TB_W          = 32,
  parameter int unsigned RST_PULSE     = 4,
  parameter bit          ENABLE_ONCE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [1:0]      rsync_q;
  logic            rst_core_n;
  logic [TB_W-1:0] time_w;
  logic            active_w, service_w, clr_cause_w, pend_w, cause_w;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  twdt_timebase #(.W(TB_W)) u_time (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .time_o (time_w)
  );

  twdt_regs #(.ADDR_W(ADDR_W), .TB_W(TB_W), .LOCK(ENABLE_ONCE)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .addr_i      (bus_addr),
    .wr_i        (bus_wr),
    .rd_i        (bus_rd),
    .wdata_i     (bus_wdata),
    .pend_i      (pend_w),
    .cause_i     (cause_w),
    .time_i      (time_w),
    .rdata_o     (bus_rdata),
    .active_o    (active_w),
    .service_o   (service_w),
    .clr_cause_o (clr_cause_w)
  );

  twdt_expiry #(.N(INTERVAL_LOG2), .RST_PULSE(RST_PULSE)) u_exp (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .active_i    (active_w),
    .service_i   (service_w),
    .clr_cause_i (clr_cause_w),
    .pend_o      (pend_w),
    .cause_o     (cause_w),
    .sys_rst_o   (sys_rst_o)
  );

  assign irq_o = pend_w;
endmodule

// File: tb/tb_twostage_wdt.sv
module tb_twostage_wdt;
  localparam int N  = 5;
  localparam int IV = 1 << N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b, srst_a, srst_b;

  twostage_wdt #(.INTERVAL_LOG2(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr & ~sel),
    .bus_rd(rd & ~sel), .bus_wdata(wdata), .bus_rdata(rdata_a),
    .irq_o(irq_a), .sys_rst_o(srst_a));

  twostage_wdt #(.INTERVAL_LOG2(N), .ENABLE_ONCE(1'b1)) dut_lock (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr & sel),
    .bus_rd(rd & sel), .bus_wdata(wdata), .bus_rdata(rdata_b),
    .irq_o(irq_b), .sys_rst_o(srst_b));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; bit cmp; string tag; } exp_t;
  exp_t        sb[$];
  exp_t        it;
  logic        rd_q = 1'b0;
  logic [31:0] got, last_rd;

  // Monitor: compares each read result against the queued expectation
  always @(posedge clk) rd_q <= rd;
  always @(negedge clk) begin
    if (rd_q) begin
      got = sel ? rdata_b : rdata_a;
      last_rd = got;
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: unexpected read got %h exp none", got);
      end else begin
        it = sb.pop_front();
        if (it.cmp) begin
          n_run++;
          if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: read got %h exp %h", it.tag, got, it.exp);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  // Driver: pushes the expectation, then issues the read
  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp,
                          input bit cmp, input string tag);
    exp_t e;
    e.exp = exp; e.cmp = cmp; e.tag = tag;
    @(negedge clk); addr = a; rd = 1'b1; sb.push_back(e);
    @(negedge clk); rd = 1'b0;
    #1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] t1, t2;
    skip(4); rst_n = 1'b1; skip(4);

    // R1: reset state
    chk("R1 irq", {31'd0, irq_a}, 32'd0);
    chk("R1 sys_rst", {31'd0, srst_a}, 32'd0);
    bus_read(4'h0, 32'h0, 1, "R1 word A");
    bus_read(4'h4, 32'h0, 1, "R1 word B");

    // R3: timebase runs freely
    bus_read(4'h8, 32'h0, 0, "R3");
    t1 = last_rd;
    bus_read(4'h8, 32'h0, 0, "R3");
    t2 = last_rd;
    chk("R3 timebase delta", t2 - t1, 32'd2);

    // R11 / R2: bit 0 and undefined bits are ignored, unknown offset reads 0
    bus_write(4'h0, 32'hFFFF_FFF1);
    bus_read(4'h0, 32'h0, 1, "R11 word A after junk write");
    skip(IV + 2);
    chk("R11 no counting", {31'd0, irq_a}, 32'd0);
    bus_read(4'hC, 32'h0, 1, "R2 undefined offset");

    // R4 / R5: enable B alone, first wrap
    bus_write(4'h4, 32'h1);
    skip(IV - 1);
    chk("R5 irq before wrap", {31'd0, irq_a}, 32'd0);
    skip(1);
    chk("R5 irq at wrap (R4 enable B)", {31'd0, irq_a}, 32'd1);
    bus_read(4'h0, 32'h4, 1, "R5 pending bit");
    bus_read(4'h4, 32'h1, 1, "R2 enable B bit");

    // R6: service clears and restarts
    bus_write(4'h0, 32'h4);
    chk("R6 irq cleared", {31'd0, irq_a}, 32'd0);
    skip(IV - 1);
    chk("R6 irq after restart early", {31'd0, irq_a}, 32'd0);
    skip(1);
    chk("R6 irq after restart", {31'd0, irq_a}, 32'd1);

    // R7: second wrap resets for exactly four cycles
    skip(IV - 1);
    chk("R7 no reset early", {31'd0, srst_a}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      skip(1);
      chk("R7 reset pulse", {31'd0, srst_a}, 32'd1);
    end
    skip(1);
    chk("R7 reset pulse end", {31'd0, srst_a}, 32'd0);
    bus_read(4'h0, 32'hC, 1, "R7 cause sticky");
    bus_write(4'h4, 32'h0);
    bus_read(4'h0, 32'hC, 1, "R7 cause after disable");

    // R8: zero writes keep flags, ones clear them
    bus_write(4'h0, 32'h0);
    bus_read(4'h0, 32'hC, 1, "R8 zero write no effect");
    bus_write(4'h0, 32'h8);
    bus_read(4'h0, 32'h4, 1, "R8 cause cleared");
    bus_write(4'h0, 32'h4);
    bus_read(4'h0, 32'h0, 1, "R8 pending cleared");

    // R9: disable stops and zeroes the interval
    bus_write(4'h0, 32'h2);
    skip(20);
    bus_write(4'h0, 32'h0);
    skip(40);
    chk("R9 stopped", {31'd0, irq_a}, 32'd0);
    bus_write(4'h0, 32'h2);
    skip(IV - 1);
    chk("R9 full interval after re-enable", {31'd0, irq_a}, 32'd0);
    skip(1);
    chk("R9 irq after re-enable", {31'd0, irq_a}, 32'd1);
    bus_write(4'h0, 32'h4);
    chk("R9 cleanup", {31'd0, irq_a}, 32'd0);

    // R10: locked instance ignores disable
    sel = 1'b1;
    bus_write(4'h0, 32'h2);
    bus_write(4'h0, 32'h0);
    bus_write(4'h4, 32'h0);
    skip(IV - 1 - 4);
    chk("R10 irq early", {31'd0, irq_b}, 32'd0);
    skip(1);
    chk("R10 still counting", {31'd0, irq_b}, 32'd1);
    bus_read(4'h0, 32'h6, 1, "R10 enable A kept");
    bus_read(4'h4, 32'h0, 1, "R10 enable B untouched");
    sel = 1'b0;

    skip(2);
    if (sb.size() != 0) chk("scoreboard drained", sb.size(), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule